// File: doc/BRIEF.md
# Bank-Sliced Low-Activity Word Memory

This block is a synchronous, single-clock memory of 4096 words of 4 bits. It is assembled from four physical banks of 1024 words each. The storage is split by address range, so each access touches exactly one bank. The two top address bits choose the bank. The ten low address bits go to all four banks at once. The memory is meant to sit in a larger datapath that issues at most one read and one write per cycle, both to the same address.

The port-level write and read enables do not act as plain enables on a free-running bank clock. Each one is turned into a clock enable for the addressed bank only, so the other three banks see no activity in that cycle. When the user clock-enable option is selected, the user input is ANDed into both derived enables. The read path registers the data inside the chosen bank and also registers the bank select from the cycle in which the read was issued. An output multiplexer then returns the word one cycle after the read. The per-bank write and read clock enables are brought out as ports so that bank activity can be observed.

Top module: `bank_sliced_ram`

## Requirements
- R1: While rst_n is low and in the first cycle after its release, rdata is 0 and every bank clock-enable output is 0 when no access is requested.
- R2: A word written at any of the 4096 addresses is returned unchanged by a later read of that address.
- R3: With the access gate open, bank_wr_ce equals 1 shifted left by addr[11:10] when wr_en is 1, and bank_rd_ce equals 1 shifted left by addr[11:10] when rd_en is 1 (bit n of each vector belongs to bank n).
- R4: When wr_en is 0, bank_wr_ce is all zero. When rd_en is 0, bank_rd_ce is all zero.
- R5: In every cycle, each of bank_wr_ce and bank_rd_ce is one-hot or all zero, and the two never name different banks.
- R6: Data for a read issued in cycle k appears on rdata after the clock edge ending cycle k, and it comes from the bank that was selected in cycle k.
- R7: In a cycle with no enabled read, rdata keeps its previous value, even when writes take place.
- R8: A read and a write to the same address in the same cycle return the word held before the write. The new word is returned by the next read.
- R9: With USE_USER_CE=1 and user_ce low, both enable vectors are all zero, no word is written, and rdata keeps its value.
- R10: Addresses that share bits 9:0 but differ in bits 11:10 hold independent words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for all banks and registers |
| rst_n | input | 1 | Active-low synchronous reset of the read path registers |
| addr | input | 12 | Word address. Bits 11:10 select the bank, bits 9:0 select the word within it |
| wdata | input | 4 | Write data |
| wr_en | input | 1 | Write request for this cycle |
| rd_en | input | 1 | Read request for this cycle |
| user_ce | input | 1 | User clock enable, combined with both requests when USE_USER_CE=1 |
| rdata | output | 4 | Registered read data |
| bank_wr_ce | output | 4 | Per-bank write clock enables |
| bank_rd_ce | output | 4 | Per-bank read clock enables |

## Verification
A read and a write can both land on one bank, and on one word, in the same cycle. The bench provokes this with a full sweep in which every address is read and rewritten with its inverted value in a single cycle. It requires the old word on rdata one cycle later, and it requires both enable vectors to be the same one-hot code. A later read sweep then requires every inverted word, which shows that the write in that shared cycle took effect.

// File: rtl/bank_sliced_ram_pkg.sv
package bank_sliced_ram_pkg;

    // Kind of access requested in a cycle, after the user gate is applied.
    typedef enum logic [1:0] {
        ACC_IDLE  = 2'b00,
        ACC_READ  = 2'b01,
        ACC_WRITE = 2'b10,
        ACC_BOTH  = 2'b11
    } access_kind_e;

    function automatic access_kind_e classify(input logic wr, input logic rd);
        return access_kind_e'({wr, rd});
    endfunction

endpackage

// File: rtl/bank_ce_decoder.sv
module bank_ce_decoder
    import bank_sliced_ram_pkg::*;
#(
    parameter int NUM_BANKS   = 4,
    parameter int SEL_W       = 2,
    parameter bit USE_USER_CE = 1'b1
) (
    input  logic [SEL_W-1:0]     bank_sel,
    input  logic                 wr_en,
    input  logic                 rd_en,
    input  logic                 user_ce,
    output logic [NUM_BANKS-1:0] wr_ce,
    output logic [NUM_BANKS-1:0] rd_ce,
    output logic                 rd_any
);

    logic         gate;
    access_kind_e kind;
    logic         wr_live;
    logic         rd_live;

    // Combining mode folds the user enable in; conversion mode ignores it.
    generate
        if (USE_USER_CE) begin : g_combine
            assign gate = user_ce;
        end else begin : g_convert
            logic unused_ce;
            assign unused_ce = user_ce;
            assign gate      = 1'b1;
        end
    endgenerate

    always_comb begin
        kind = classify(wr_en & gate, rd_en & gate);
        unique case (kind)
            ACC_IDLE:  begin wr_live = 1'b0; rd_live = 1'b0; end
            ACC_READ:  begin wr_live = 1'b0; rd_live = 1'b1; end
            ACC_WRITE: begin wr_live = 1'b1; rd_live = 1'b0; end
            ACC_BOTH:  begin wr_live = 1'b1; rd_live = 1'b1; end
            default:   begin wr_live = 1'b0; rd_live = 1'b0; end
        endcase
    end

    generate
        for (genvar b = 0; b < NUM_BANKS; b++) begin : g_dec
            logic hit;
            assign hit      = (bank_sel == SEL_W'(b));
            assign wr_ce[b] = wr_live & hit;
            assign rd_ce[b] = rd_live & hit;
        end
    endgenerate

    assign rd_any = rd_live;

endmodule

// File: rtl/ram_bank.sv
module ram_bank #(
    parameter int DATA_W = 4,
    parameter int LOW_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ce,
    input  logic              rd_ce,
    input  logic [LOW_W-1:0]  word_addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] q
);

    localparam int DEPTH = 1 << LOW_W;

    logic [DATA_W-1:0] store [DEPTH];

    // Storage is touched only when this bank's write enable is active.
    always_ff @(posedge clk) begin
        if (wr_ce) begin
            store[word_addr] <= wdata;
        end
    end

    // The read register loads only on this bank's read enable. The store
    // is sampled before the same-edge write lands, which gives old data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (rd_ce) begin
            q <= store[word_addr];
        end
    end

endmodule

// File: rtl/bank_read_mux.sv
module bank_read_mux #(
    parameter int NUM_BANKS = 4,
    parameter int SEL_W     = 2,
    parameter int DATA_W    = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        rd_any,
    input  logic [SEL_W-1:0]            bank_sel,
    input  logic [NUM_BANKS*DATA_W-1:0] bank_q,
    output logic [DATA_W-1:0]           rdata
);

    logic [SEL_W-1:0] sel_q;

    // The select follows the read that was issued, so it stays paired with
    // the bank register that was loaded on that edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
        end else if (rd_any) begin
            sel_q <= bank_sel;
        end
    end

    assign rdata = bank_q[sel_q*DATA_W +: DATA_W];

endmodule

// File: rtl/bank_sliced_ram.sv
module bank_sliced_ram #(
    parameter int ADDR_W      = 12,
    parameter int DATA_W      = 4,
    parameter int NUM_BANKS   = 4,
    parameter bit USE_USER_CE = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [DATA_W-1:0]    wdata,
    input  logic                 wr_en,
    input  logic                 rd_en,
    input  logic                 user_ce,
    output logic [DATA_W-1:0]    rdata,
    output logic [NUM_BANKS-1:0] bank_wr_ce,
    output logic [NUM_BANKS-1:0] bank_rd_ce
);

    localparam int SEL_W = $clog2(NUM_BANKS);
    localparam int LOW_W = ADDR_W - SEL_W;

    logic [SEL_W-1:0]            bank_sel;
    logic [LOW_W-1:0]            word_addr;
    logic                        rd_any;
    logic [NUM_BANKS*DATA_W-1:0] bank_q_flat;

    assign bank_sel  = addr[ADDR_W-1 -: SEL_W];
    assign word_addr = addr[LOW_W-1:0];

    bank_ce_decoder #(
        .NUM_BANKS  (NUM_BANKS),
        .SEL_W      (SEL_W),
        .USE_USER_CE(USE_USER_CE)
    ) u_dec (
        .bank_sel(bank_sel),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .user_ce (user_ce),
        .wr_ce   (bank_wr_ce),
        .rd_ce   (bank_rd_ce),
        .rd_any  (rd_any)
    );

    generate
        for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
            ram_bank #(
                .DATA_W(DATA_W),
                .LOW_W (LOW_W)
            ) u_bank (
                .clk      (clk),
                .rst_n    (rst_n),
                .wr_ce    (bank_wr_ce[b]),
                .rd_ce    (bank_rd_ce[b]),
                .word_addr(word_addr),
                .wdata    (wdata),
                .q        (bank_q_flat[b*DATA_W +: DATA_W])
            );
        end
    endgenerate

    bank_read_mux #(
        .NUM_BANKS(NUM_BANKS),
        .SEL_W    (SEL_W),
        .DATA_W   (DATA_W)
    ) u_mux (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_any  (rd_any),
        .bank_sel(bank_sel),
        .bank_q  (bank_q_flat),
        .rdata   (rdata)
    );

endmodule

// File: rtl/bank_sliced_ram_chk.sv
module bank_sliced_ram_chk #(
    parameter int NUM_BANKS   = 4,
    parameter int SEL_W       = 2,
    parameter int DATA_W      = 4,
    parameter bit USE_USER_CE = 1'b1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [SEL_W-1:0]     bank_sel,
    input logic                 wr_en,
    input logic                 rd_en,
    input logic                 user_ce,
    input logic [DATA_W-1:0]    rdata,
    input logic [NUM_BANKS-1:0] bank_wr_ce,
    input logic [NUM_BANKS-1:0] bank_rd_ce
);

    logic open_gate;
    assign open_gate = user_ce || !USE_USER_CE;

    p_onehot_ce_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bank_wr_ce) && $onehot0(bank_rd_ce) && $onehot0(bank_wr_ce | bank_rd_ce));

    p_idle_wr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |-> bank_wr_ce == '0);

    p_idle_rd_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> bank_rd_ce == '0);

    p_decode_wr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && open_gate) |-> bank_wr_ce[bank_sel]);

    p_decode_rd_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && open_gate) |-> bank_rd_ce[bank_sel]);

    p_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !open_gate |-> (bank_wr_ce == '0 && bank_rd_ce == '0));

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && open_gate) |=> $stable(rdata));

endmodule

bind bank_sliced_ram bank_sliced_ram_chk #(
    .NUM_BANKS  (NUM_BANKS),
    .SEL_W      (SEL_W),
    .DATA_W     (DATA_W),
    .USE_USER_CE(USE_USER_CE)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bank_sel  (addr[ADDR_W-1 -: SEL_W]),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .user_ce   (user_ce),
    .rdata     (rdata),
    .bank_wr_ce(bank_wr_ce),
    .bank_rd_ce(bank_rd_ce)
);

// File: tb/bank_sliced_ram_bench.sv
module bank_sliced_ram_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WORDS      = 4096;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] addr = '0;
    logic [3:0]  wdata = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic        user_ce = 1'b1;
    logic [3:0]  rdata;
    logic [3:0]  bank_wr_ce;
    logic [3:0]  bank_rd_ce;

    int   total = 0;
    int   bad = 0;
    bit   finished = 1'b0;

    logic [3:0] model_mem [WORDS];
    logic [3:0] exp_rdata = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bank_sliced_ram u_bank_sliced_ram (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (addr),
        .wdata     (wdata),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .user_ce   (user_ce),
        .rdata     (rdata),
        .bank_wr_ce(bank_wr_ce),
        .bank_rd_ce(bank_rd_ce)
    );

    function automatic logic [3:0] pattern(input int a);
        return 4'((a ^ (a >> 4) ^ (a >> 8) ^ 5) & 15);
    endfunction

    task automatic check4(input string tag, input logic [3:0] act, input logic [3:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drives one cycle just after a falling edge, checks the enables,
    // then checks rdata at the next falling edge.
    task automatic step(input logic [11:0] a, input logic [3:0] wd,
                        input logic we, input logic re, input logic uce,
                        input string tag);
        logic [3:0] exp_w;
        logic [3:0] exp_r;
        addr = a; wdata = wd; wr_en = we; rd_en = re; user_ce = uce;
        exp_w = (we && uce) ? 4'(1 << a[11:10]) : 4'b0;
        exp_r = (re && uce) ? 4'(1 << a[11:10]) : 4'b0;
        #1;
        check4({tag, " wr_ce"}, bank_wr_ce, exp_w);
        check4({tag, " rd_ce"}, bank_rd_ce, exp_r);
        if (re && uce) exp_rdata = model_mem[a];
        if (we && uce) model_mem[a] = wd;
        @(negedge clk);
        check4({tag, " rdata"}, rdata, exp_rdata);
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        #1;
        check4("R1 rdata in reset", rdata, 4'h0);
        check4("R1 wr_ce in reset", bank_wr_ce, 4'h0);
        check4("R1 rd_ce in reset", bank_rd_ce, 4'h0);
        @(negedge clk);
        rst_n = 1'b1;
        step(12'h000, 4'h0, 1'b0, 1'b0, 1'b1, "R1 first idle cycle");

        // R3, R7, R10: write every word; rdata must hold at 0
        for (int a = 0; a < WORDS; a++) begin
            step(12'(a), pattern(a), 1'b1, 1'b0, 1'b1, "R3 R7 write sweep");
        end

        // R2, R6, R10: read every word
        for (int a = 0; a < WORDS; a++) begin
            step(12'(a), 4'h0, 1'b0, 1'b1, 1'b1, "R2 R6 R10 read sweep");
        end

        // R8: read and write the same word together; old data returned
        for (int a = 0; a < WORDS; a++) begin
            step(12'(a), ~pattern(a), 1'b1, 1'b1, 1'b1, "R8 same-cycle read/write");
        end

        // R9: gate closed; nothing may change
        for (int b = 0; b < 4; b++) begin
            step(12'(b * 1024 + 77), 4'h9, 1'b1, 1'b1, 1'b0, "R9 gated access");
        end
        for (int b = 0; b < 4; b++) begin
            step(12'(b * 1024 + 77), 4'h0, 1'b0, 1'b1, 1'b1, "R9 gated word unchanged");
        end

        // R4: idle cycles hold rdata
        repeat (4) step(12'hFFF, 4'hF, 1'b0, 1'b0, 1'b1, "R4 R7 idle");

        // R6: back-to-back reads hopping across banks with shared low bits
        for (int i = 0; i < 16; i++) begin
            step(12'(((i * 3) % 4) * 1024 + 513), 4'h0, 1'b0, 1'b1, 1'b1, "R6 R10 bank hop");
        end

        // R8: new word visible on the read after the write
        step(12'h5A5, 4'h3, 1'b1, 1'b1, 1'b1, "R8 write with read");
        step(12'h5A5, 4'h0, 1'b0, 1'b1, 1'b1, "R8 new word next read");

        // R2: final full read of inverted contents
        for (int a = 0; a < WORDS; a++) begin
            step(12'(a), 4'h0, 1'b0, 1'b1, 1'b1, "R2 final read sweep");
        end

        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule